// File: doc/BRIEF.md
# PHY Initialization Pulse Sequencer

This block sits inside a storage-interface PHY and performs the self-timed start-up handshake that the PHY needs after a clock change. Software writes a single control register. That register holds four 4-bit phase lengths, two mode bits and a start bit. Setting the start bit launches a fixed chain of phases. First a synchronizer reset pulse is driven. A quiet gap follows, then a synchronizer enable pulse, then a settle wait. A fixed tail of eight cycles closes the chain.

The start bit stays set while the chain runs and clears by itself at the end, so software learns that initialization is complete by polling it. A one-cycle completion strobe is also given for hardware that prefers an event. The whole block runs on one clock, and the register is reached through a plain write strobe with a read-data bus that is always valid.

Top module: `phy_init_seq`

## Requirements
- R1: After reset the register reads 0x00000000 and sync_rst_o, sync_en_o and init_done_o are low.
- R2: A write while idle stores data bits [15:0] (field 0 at [3:0], 1 at [7:4], 2 at [11:8], 3 at [15:12]) and bits 29 (slow) and 28 (sdio). All other bits read 0. A write with bit 31 at 0 starts nothing.
- R3: A write while idle with bit 31 at 1 starts a run. Bit 31 then reads 1 for exactly F0+F1+F2+F3+8 cycles after the write edge, where Fk is the written field k, and reads 0 afterwards.
- R4: In a run, sync_rst_o is high for F0 cycles starting in the cycle after the write edge. Both outputs are then low for F1 cycles, sync_en_o is high for F2 cycles, and both are low for the remaining F3+8 cycles. Neither output is high outside a run.
- R5: sync_rst_o and sync_en_o are never high in the same cycle.
- R6: A field of 0 skips its phase, taking no cycle. With all four fields at 0 a run lasts exactly 8 cycles.
- R7: init_done_o is high for exactly one cycle: the first cycle in which bit 31 reads 0 after a run.
- R8: A write with bit 31 at 1 during a run neither restarts nor lengthens the run, and bits [15:0] keep their values.
- R9: A write with bit 31 at 0 during a run does not abort it, and bits [15:0] keep their values.
- R10: Bits 29 and 28 take the written value on every write, including writes during a run, and a run never changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| sync_rst_o | output | 1 | Synchronizer reset pulse |
| sync_en_o | output | 1 | Synchronizer enable pulse |
| init_done_o | output | 1 | One-cycle strobe at end of a run |

## Verification
The bench aims at off-by-one lengths by comparing every cycle of each run against a predicted trace. A design that loads a count one too high or too low would stretch or shorten a pulse, or drop the completion strobe a cycle off. Runs with zero-length phases and an all-zero run catch a design that spends a cycle in a skipped phase. Writes issued in the middle of a run catch a design that restarts, aborts or accepts new phase lengths while busy, or that freezes the mode bits. An all-ones run checks that the longest phases do not wrap.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;
  localparam int REG_W    = 32;
  localparam int TRIG_BIT = 31;
  localparam int SLOW_BIT = 29;
  localparam int SDIO_BIT = 28;
  localparam int FIELD_W  = 4;
  localparam int N_FIELDS = 4;
  localparam int TAIL_LEN = 8;

  // phase value k+1 is timed by field k
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RST    = 3'd1,
    PH_GAP    = 3'd2,
    PH_EN     = 3'd3,
    PH_SETTLE = 3'd4,
    PH_TAIL   = 3'd5
  } phase_e;
endpackage

// File: rtl/phy_init_regs.sv
module phy_init_regs
  import phy_init_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int FLD_W  = FIELD_W,
  parameter int N_FLD  = N_FIELDS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic                   busy_i,
  output logic                   start_o,
  output logic [N_FLD*FLD_W-1:0] fields_o,
  output logic [DATA_W-1:0]      rd_data_o
);
  localparam int FLDS_W = N_FLD * FLD_W;

  logic [FLDS_W-1:0] fields_q;
  logic              slow_q, sdio_q;
  logic              wr_idle;

  assign wr_idle = wr_en_i && !busy_i;
  assign start_o = wr_idle && wr_data_i[TRIG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q <= '0;
      slow_q   <= 1'b0;
      sdio_q   <= 1'b0;
    end else begin
      if (wr_idle) fields_q <= wr_data_i[FLDS_W-1:0];
      if (wr_en_i) begin
        slow_q <= wr_data_i[SLOW_BIT];
        sdio_q <= wr_data_i[SDIO_BIT];
      end
    end
  end

  // sequencer sees the lengths being written on the start edge
  assign fields_o = start_o ? wr_data_i[FLDS_W-1:0] : fields_q;

  always_comb begin
    rd_data_o              = '0;
    rd_data_o[FLDS_W-1:0]  = fields_q;
    rd_data_o[SLOW_BIT]    = slow_q;
    rd_data_o[SDIO_BIT]    = sdio_q;
    rd_data_o[TRIG_BIT]    = busy_i;
  end
endmodule

// File: rtl/phy_init_fsm.sv
module phy_init_fsm
  import phy_init_pkg::*;
#(
  parameter int FLD_W = FIELD_W,
  parameter int N_FLD = N_FIELDS,
  parameter int TAIL  = TAIL_LEN
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [N_FLD*FLD_W-1:0] fields_i,
  output logic                   busy_o,
  output logic                   sync_rst_o,
  output logic                   sync_en_o,
  output logic                   done_o
);
  localparam int TAIL_W = $clog2(TAIL);
  localparam int CNT_W  = (FLD_W > TAIL_W) ? FLD_W : TAIL_W;

  phase_e           phase_q, phase_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_load;
  logic             done_q;

  // first programmed phase after cur with a non-zero length, else tail
  function automatic phase_e next_after(input phase_e cur,
                                        input logic [N_FLD*FLD_W-1:0] f);
    phase_e r;
    r = PH_TAIL;
    for (int k = N_FLD - 1; k >= 0; k--) begin
      if ((k + 1) > int'(cur) && f[k*FLD_W +: FLD_W] != '0) r = phase_e'(k + 1);
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] len_of(input phase_e p,
                                              input logic [N_FLD*FLD_W-1:0] f);
    logic [CNT_W-1:0] v;
    int               idx;
    idx = int'(p) - 1;
    if (p == PH_TAIL)  v = CNT_W'(TAIL - 1);
    else if (idx < 0)  v = '0;
    else               v = CNT_W'(f[idx*FLD_W +: FLD_W]) - CNT_W'(1);
    return v;
  endfunction

  always_comb begin
    phase_nxt = next_after(phase_q, fields_i);
    cnt_load  = len_of(phase_nxt, fields_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (phase_q == PH_TAIL) && (cnt_q == '0);
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          phase_q <= phase_nxt;
          cnt_q   <= cnt_load;
        end
      end else if (cnt_q == '0) begin
        if (phase_q == PH_TAIL) begin
          phase_q <= PH_IDLE;
        end else begin
          phase_q <= phase_nxt;
          cnt_q   <= cnt_load;
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy_o     = (phase_q != PH_IDLE);
  assign sync_rst_o = (phase_q == PH_RST);
  assign sync_en_o  = (phase_q == PH_EN);
  assign done_o     = done_q;
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_init_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int FLD_W  = FIELD_W,
  parameter int N_FLD  = N_FIELDS,
  parameter int TAIL   = TAIL_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sync_rst_o,
  output logic              sync_en_o,
  output logic              init_done_o
);
  logic                   busy, start;
  logic [N_FLD*FLD_W-1:0] fields;

  phy_init_regs #(.DATA_W(DATA_W), .FLD_W(FLD_W), .N_FLD(N_FLD)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .busy_i    (busy),
    .start_o   (start),
    .fields_o  (fields),
    .rd_data_o (rd_data_o)
  );

  phy_init_fsm #(.FLD_W(FLD_W), .N_FLD(N_FLD), .TAIL(TAIL)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .fields_i   (fields),
    .busy_o     (busy),
    .sync_rst_o (sync_rst_o),
    .sync_en_o  (sync_en_o),
    .done_o     (init_done_o)
  );
endmodule

// File: rtl/phy_init_seq_chk.sv
module phy_init_seq_chk
  import phy_init_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              sync_rst_o,
  input logic              sync_en_o,
  input logic              init_done_o
);
  logic trig;
  assign trig = rd_data_o[TRIG_BIT];

  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_rst_o && sync_en_o));

  a_r4_pulse_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_rst_o || sync_en_o) |-> trig);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> !init_done_o);

  a_r7_done_at_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (!trig && $past(trig)));

  a_r9_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> (trig || init_done_o));

  a_r8_fields_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> $stable(rd_data_o[15:0]));

  a_r10_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o[SLOW_BIT:SDIO_BIT]));

  a_r10_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[SLOW_BIT:SDIO_BIT] == $past(wr_data_i[SLOW_BIT:SDIO_BIT])));
endmodule

bind phy_init_seq phy_init_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/phy_init_seq_test.sv
module phy_init_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sync_rst, sync_en, init_done;

  int n_vec  = 0;
  int n_miss = 0;

  typedef struct {
    logic [3:0] bits; // {sync_rst, sync_en, trigger, done}
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  phy_init_seq uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .sync_rst_o  (sync_rst),
    .sync_en_o   (sync_en),
    .init_done_o (init_done)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] b, input string tag);
    item_t it;
    it.bits = b;
    it.tag  = tag;
    exp_q.push_back(it);
  endtask

  // expected per-cycle trace of a run from the written lengths
  task automatic push_run(input logic [31:0] d, input string tag);
    for (int i = 0; i < int'(d[3:0]); i++)   push(4'b1010, tag);
    for (int i = 0; i < int'(d[7:4]); i++)   push(4'b0010, tag);
    for (int i = 0; i < int'(d[11:8]); i++)  push(4'b0110, tag);
    for (int i = 0; i < int'(d[15:12]) + 8; i++) push(4'b0010, tag);
    push(4'b0001, {tag, "/R7"});
    push(4'b0000, {tag, "/R7"});
  endtask

  // register write; expect_run queues the trace after the write edge
  task automatic write(input logic [31:0] d, input bit expect_run, input string tag);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    if (expect_run) push_run(d, tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && exp_q.size() != 0) begin
      item_t it;
      logic [3:0] act;
      it  = exp_q.pop_front();
      act = {sync_rst, sync_en, rd_data[31], init_done};
      n_vec++;
      if (act !== it.bits) begin
        n_miss++;
        $display("FAIL %s: {rst,en,trig,done} got %b expected %b", it.tag, act, it.bits);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_miss++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check32("R1 reg", rd_data, 32'h0);
    check32("R1 outs", {29'd0, sync_rst, sync_en, init_done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check32("R1 reg after release", rd_data, 32'h0);

    // R2 idle write, no trigger; reserved bits read 0
    write(32'h7FFF_4321, 1'b0, "R2");
    check32("R2 readback", rd_data, 32'h3000_4321);
    repeat (3) @(negedge clk);
    check32("R2 no run", {29'd0, sync_rst, sync_en, rd_data[31]}, 32'h0);

    // R3 R4 mixed lengths
    write(32'h8000_2131, 1'b1, "R3/R4 run1");
    wait_drain();
    check32("R3 R10 after run1", rd_data, 32'h0000_2131);

    // R6 all-zero run, 8 cycles; R10 mode kept
    write(32'hA000_0000, 1'b1, "R6 zero run");
    wait_drain();
    check32("R6 R10 after zero run", rd_data, 32'h2000_0000);

    // R6 skipped pulses, R8 R9 R10 writes during run
    write(32'h9000_5040, 1'b1, "R6/R8/R9 run3");
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h8000_FFFF; // R8 retrigger ignored
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check32("R8 fields kept", {16'd0, rd_data[15:0]}, 32'h0000_5040);
    wr_en = 1'b1; wr_data = 32'h2000_0777; // R9 clear does not abort
    @(negedge clk);
    wr_en = 1'b0;
    check32("R10 mode during run", {30'd0, rd_data[29:28]}, 32'h2);
    check32("R9 still running", {31'd0, rd_data[31]}, 32'h1);
    wait_drain();
    check32("R8 R9 R10 after run3", rd_data, 32'h2000_5040);

    // longest run
    write(32'h9000_FFFF, 1'b1, "R3/R4 max run");
    wait_drain();
    check32("R3 after max run", rd_data, 32'h1000_FFFF);

    // back-to-back start right after completion
    write(32'h8000_0112, 1'b1, "R3/R4 run5");
    wait_drain();
    check32("R3 after run5", rd_data, 32'h0000_0112);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule